// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block is one DMA channel. It copies elements between a fixed device address and a memory address that advances after each element. Software chooses one of two run modes. In single mode the descriptor comes straight from four input words. In chain mode the engine reads 16-byte descriptors from memory over a simple master port and follows the chain until a descriptor says it is the last one. The master port carries descriptor fetches and element moves alike.

Each element waits for a request from the peripheral, then takes one read from the source and one write to the destination. A descriptor is four words at byte offsets 0x0, 0x4, 0x8 and 0xC, in this order: device address, memory address, size word, link word. Two outputs pulse for a single cycle: one when a descriptor asks for an interrupt, and one when a descriptor is malformed. A 2-bit state output shows whether the channel is idle, reading a descriptor, waiting for the peripheral, or moving data.

Top module: `dmach_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `state_o` is 0, `m_req` is low and `done_o` and `err_o` are low.
- R2: `state_o` reads 0 when idle, 1 while a descriptor is fetched or checked, 2 while waiting for the peripheral, and 3 while an element moves or a descriptor finishes. It returns to 0 only when the run is over.
- R3: `cfg_mode` is 0 off, 1 chain, 2 single and 3 off. In single mode a `start` pulse runs the descriptor held on the `reg_*` inputs with no bus fetch. In that mode the link word's follow bit (bit 1) is ignored.
- R4: In chain mode a `start` pulse fetches four words, in order, from `reg_next` with bits [1:0] cleared, at offsets +0, +4, +8 and +12. While a finished descriptor's link word has bit 1 set, the next descriptor is fetched from that word with its low two bits cleared.
- R5: Size word bits [13:12] give the element width: 3 is 1 byte, 2 is 2 bytes, 0 is 4 bytes. Bits [10:0] give the element count. The memory address advances by the element width after each element, and the device address stays fixed.
- R6: Each element is one read of the source, then one write of the read data to the destination. With `cfg_to_dev` = 1 the source is memory and the destination is the device; with 0 the direction is reversed.
- R7: After each element, and before the first one, the channel waits in state 2 with no bus access until `dreq` is sampled high. Each high sample in state 2 starts exactly one element.
- R8: A descriptor is malformed if its width code is 1, or if its count is above 0x3FF with width code 3 or 2. Count 0x3FF with width code 2 is valid. With width code 0 every 11-bit count is valid, up to 0x7FF. A malformed descriptor pulses `err_o` and `done_o` in the same cycle, moves no elements, and the channel goes idle.
- R9: `done_o` pulses for one cycle at the end of every descriptor whose link word has bit 0 set, and not for descriptors whose bit 0 is clear.
- R10: If `cfg_mode` is set to off while the channel waits in state 2, it goes idle on the next clock and makes no further bus access.
- R11: A descriptor with count 0 finishes with no element access and still follows its link word's control bits.
- R12: Once `m_req` is raised, it stays high with `m_addr` and `m_we` unchanged until a cycle in which `m_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Run mode: 0 off, 1 chain, 2 single, 3 off |
| cfg_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| start | input | 1 | Begin a run when idle |
| reg_dev_addr | input | 32 | Single-mode device address |
| reg_mem_addr | input | 32 | Single-mode memory address |
| reg_size | input | 32 | Single-mode size word (width, count) |
| reg_next | input | 32 | Single-mode link word; chain-mode first descriptor address |
| dreq | input | 1 | Peripheral request, one element per high sample in wait |
| m_req | output | 1 | Master port request |
| m_we | output | 1 | Master port write (1) or read (0) |
| m_addr | output | 32 | Master port byte address |
| m_wdata | output | 32 | Master port write data |
| m_ack | input | 1 | Master port acknowledge; completes the beat |
| m_rdata | input | 32 | Master port read data, valid with `m_ack` |
| state_o | output | 2 | Channel state code |
| done_o | output | 1 | End-of-descriptor interrupt pulse |
| err_o | output | 1 | Malformed descriptor pulse |

## Verification
The hardest situation to reach is a chain whose descriptors differ in width and interrupt bit, run while the master port stalls and the peripheral request is sparse. This is where fetch beats, element beats and per-descriptor done pulses can drift out of order. The bench writes a three-descriptor chain into its own memory model, acknowledges only two cycles in three, and raises `dreq` only one cycle in four. A queue predicts every bus beat, and each beat is compared on the clock it is accepted. The limit cases are reached with single descriptors: the count ceiling for each width class, and an abort while the channel waits with `dreq` held low.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int CNT_W      = 11;
    localparam int WID_LSB    = 12;
    localparam logic [CNT_W-1:0] CNT_MAX_NARROW = CNT_W'(11'h3FF);

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHAIN  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        WID_B4  = 2'd0,
        WID_BAD = 2'd1,
        WID_B2  = 2'd2,
        WID_B1  = 2'd3
    } width_e;

    typedef enum logic [2:0] {
        F_IDLE, F_FETCH, F_CHECK, F_WAIT, F_READ, F_WRITE, F_END
    } fsm_e;

    typedef struct packed {
        logic [WORD_W-1:0] dev;
        logic [WORD_W-1:0] mem;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] next;
    } desc_t;

    function automatic logic [2:0] elem_bytes(input width_e w);
        case (w)
            WID_B1:  return 3'd1;
            WID_B2:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] pub_state(input fsm_e s);
        case (s)
            F_IDLE:           return 2'd0;
            F_FETCH, F_CHECK: return 2'd1;
            F_WAIT:           return 2'd2;
            default:          return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/dmach_desc_check.sv
module dmach_desc_check
    import dmach_pkg::*;
(
    input  logic [WORD_W-1:0] size_w,
    output logic              bad,
    output logic              empty,
    output logic [2:0]        bytes
);
    width_e            wid;
    logic [CNT_W-1:0]  cnt;
    logic              unused_size;

    assign wid         = width_e'(size_w[WID_LSB +: 2]);
    assign cnt         = size_w[CNT_W-1:0];
    assign unused_size = ^{size_w[WORD_W-1:WID_LSB+2], size_w[WID_LSB-1:CNT_W]};

    always_comb begin
        case (wid)
            WID_B1, WID_B2: bad = (cnt > CNT_MAX_NARROW);
            // the count field is only as wide as the 4-byte limit
            WID_B4:         bad = 1'b0;
            default:        bad = 1'b1;
        endcase
    end

    assign empty = (cnt == '0);
    assign bytes = elem_bytes(wid);

endmodule

// File: rtl/dmach_desc_store.sv
module dmach_desc_store
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_regs,
    input  desc_t             regs_in,
    input  logic              fetch_we,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [WORD_W-1:0] fetch_data,
    input  logic              step,
    input  logic [2:0]        step_bytes,
    output desc_t             cur,
    output logic [CNT_W-1:0]  remaining
);
    localparam int W_DEV  = 0;
    localparam int W_MEM  = 1;
    localparam int W_SIZE = 2;
    localparam int W_NEXT = 3;

    logic [WORD_W-1:0] words   [DESC_WORDS];
    logic [WORD_W-1:0] reg_arr [DESC_WORDS];

    assign reg_arr[W_DEV]  = regs_in.dev;
    assign reg_arr[W_MEM]  = regs_in.mem;
    assign reg_arr[W_SIZE] = regs_in.size;
    assign reg_arr[W_NEXT] = regs_in.next;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DESC_WORDS; w++) words[w] <= '0;
            remaining <= '0;
        end else begin
            for (int w = 0; w < DESC_WORDS; w++) begin
                if (load_regs)
                    words[w] <= reg_arr[w];
                else if (fetch_we && fetch_idx == IDX_W'(w))
                    words[w] <= fetch_data;
                else if (step && w == W_MEM)
                    words[w] <= words[w] + WORD_W'(step_bytes);
            end
            if (load_regs)
                remaining <= regs_in.size[CNT_W-1:0];
            else if (fetch_we && fetch_idx == IDX_W'(W_SIZE))
                remaining <= fetch_data[CNT_W-1:0];
            else if (step)
                remaining <= remaining - CNT_W'(1);
        end
    end

    assign cur = '{dev: words[W_DEV], mem: words[W_MEM],
                   size: words[W_SIZE], next: words[W_NEXT]};

endmodule

// File: rtl/dmach_bus_mux.sv
module dmach_bus_mux
    import dmach_pkg::*;
(
    input  fsm_e              st,
    input  logic [WORD_W-1:0] ptr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] cur_dev,
    input  logic [WORD_W-1:0] cur_mem,
    input  logic              to_dev,
    input  logic [WORD_W-1:0] xfer,
    output logic              m_req,
    output logic              m_we,
    output logic [WORD_W-1:0] m_addr,
    output logic [WORD_W-1:0] m_wdata
);
    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        case (st)
            F_FETCH: begin
                m_req  = 1'b1;
                m_addr = ptr + WORD_W'({idx, 2'b00});
            end
            F_READ: begin
                m_req  = 1'b1;
                m_addr = to_dev ? cur_mem : cur_dev;
            end
            F_WRITE: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = to_dev ? cur_dev : cur_mem;
                m_wdata = xfer;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_to_dev,
    input  logic              start,
    input  logic [WORD_W-1:0] reg_dev_addr,
    input  logic [WORD_W-1:0] reg_mem_addr,
    input  logic [WORD_W-1:0] reg_size,
    input  logic [WORD_W-1:0] reg_next,
    input  logic              dreq,
    output logic              m_req,
    output logic              m_we,
    output logic [WORD_W-1:0] m_addr,
    output logic [WORD_W-1:0] m_wdata,
    input  logic              m_ack,
    input  logic [WORD_W-1:0] m_rdata,
    output logic [1:0]        state_o,
    output logic              done_o,
    output logic              err_o
);
    fsm_e              st;
    mode_e             mode;
    logic              run_ok;
    logic [WORD_W-1:0] ptr;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] xfer;
    desc_t             regs_in;
    desc_t             cur;
    logic [CNT_W-1:0]  remaining;
    logic              bad, empty;
    logic [2:0]        bytes;
    logic              load_regs, fetch_we, step;

    assign mode   = mode_e'(cfg_mode);
    assign run_ok = (mode == MODE_CHAIN) || (mode == MODE_SINGLE);

    assign regs_in = '{dev: reg_dev_addr, mem: reg_mem_addr,
                       size: reg_size, next: reg_next};

    assign load_regs = (st == F_IDLE) && start && (mode == MODE_SINGLE);
    assign fetch_we  = (st == F_FETCH) && m_ack;
    assign step      = (st == F_WRITE) && m_ack;

    dmach_desc_store u_store (
        .clk(clk), .rst(rst),
        .load_regs(load_regs), .regs_in(regs_in),
        .fetch_we(fetch_we), .fetch_idx(idx), .fetch_data(m_rdata),
        .step(step), .step_bytes(bytes),
        .cur(cur), .remaining(remaining)
    );

    dmach_desc_check u_check (
        .size_w(cur.size), .bad(bad), .empty(empty), .bytes(bytes)
    );

    dmach_bus_mux u_mux (
        .st(st), .ptr(ptr), .idx(idx),
        .cur_dev(cur.dev), .cur_mem(cur.mem),
        .to_dev(cfg_to_dev), .xfer(xfer),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= F_IDLE;
            ptr  <= '0;
            idx  <= '0;
            xfer <= '0;
        end else begin
            case (st)
                F_IDLE: if (start && run_ok) begin
                    if (mode == MODE_SINGLE) begin
                        st <= F_CHECK;
                    end else begin
                        ptr <= {reg_next[WORD_W-1:2], 2'b00};
                        idx <= '0;
                        st  <= F_FETCH;
                    end
                end
                F_FETCH: if (m_ack) begin
                    idx <= idx + IDX_W'(1);
                    if (idx == IDX_W'(DESC_WORDS - 1)) st <= F_CHECK;
                end
                F_CHECK: begin
                    if (bad)        st <= F_IDLE;
                    else if (empty) st <= F_END;
                    else            st <= F_WAIT;
                end
                F_WAIT: begin
                    if (!run_ok)   st <= F_IDLE;
                    else if (dreq) st <= F_READ;
                end
                F_READ: if (m_ack) begin
                    xfer <= m_rdata;
                    st   <= F_WRITE;
                end
                F_WRITE: if (m_ack) begin
                    if (remaining == CNT_W'(1)) st <= F_END;
                    else if (!run_ok)           st <= F_IDLE;
                    else                        st <= F_WAIT;
                end
                F_END: begin
                    if (cur.next[1] && mode == MODE_CHAIN) begin
                        ptr <= {cur.next[WORD_W-1:2], 2'b00};
                        idx <= '0;
                        st  <= F_FETCH;
                    end else begin
                        st <= F_IDLE;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    assign state_o = pub_state(st);
    assign err_o   = (st == F_CHECK) && bad;
    assign done_o  = err_o || ((st == F_END) && cur.next[0]);

endmodule

// File: rtl/dmach_engine_chk.sv
module dmach_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_mode,
    input logic        m_req,
    input logic        m_we,
    input logic [31:0] m_addr,
    input logic        m_ack,
    input logic [1:0]  state_o,
    input logic        done_o,
    input logic        err_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0) |-> (!m_req && !err_o));

    p_wait_no_bus_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) |-> !m_req);

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd0 && state_o == 2'd2) |=> (state_o == 2'd0));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

endmodule

bind dmach_engine dmach_engine_chk u_chk (.*);

// File: tb/sim_dmach_engine.sv
module sim_dmach_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_to_dev = 1'b0;
    logic        start = 1'b0;
    logic [31:0] reg_dev_addr = '0, reg_mem_addr = '0, reg_size = '0, reg_next = '0;
    logic        dreq = 1'b0;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [1:0]  state_o;
    logic        done_o, err_o;

    always #4 clk = ~clk;  // 125 MHz

    dmach_engine u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_to_dev(cfg_to_dev),
        .start(start), .reg_dev_addr(reg_dev_addr), .reg_mem_addr(reg_mem_addr),
        .reg_size(reg_size), .reg_next(reg_next), .dreq(dreq),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata),
        .state_o(state_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } op_t;

    logic [31:0] mem [0:4095];
    op_t exp_q[$];
    op_t cur_op;
    int  n_chk = 0, n_fail = 0;
    int  n_done = 0, n_err = 0, n_elem_rd = 0, n_ops = 0, grants = 0;
    int  cyc = 0;
    bit  ack_stall = 0, dreq_low = 0, dreq_sparse = 0, ack_now = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // bus responder, peripheral request and per-clock comparison
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            m_ack = 1'b0;
            dreq  = 1'b0;
        end else begin
            if (done_o) n_done++;
            if (err_o)  n_err++;
            ack_now = m_req && (!ack_stall || (cyc % 3) != 0);
            m_ack   = ack_now;
            if (ack_now) begin
                n_ops++;
                if (!m_we && state_o == 2'd3) n_elem_rd++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected bus access", m_addr, 32'h0);
                end else begin
                    cur_op = exp_q.pop_front();
                    check(m_we == cur_op.we && m_addr == cur_op.addr, cur_op.tag,
                          "bus address", m_addr, cur_op.addr);
                    if (cur_op.we)
                        check(m_wdata == cur_op.data, cur_op.tag, "write data",
                              m_wdata, cur_op.data);
                end
                if (m_we) mem[m_addr[13:2]] = m_wdata;
                else      m_rdata = mem[m_addr[13:2]];
            end
            dreq = !dreq_low && (!dreq_sparse || (cyc % 4) == 1);
            if (state_o == 2'd2 && dreq) grants++;
        end
    end

    // reference model: every expected bus beat and pulse, from the requirements
    task automatic expect_run(input bit single, input bit to_dev,
                              input logic [31:0] dv, input logic [31:0] mm,
                              input logic [31:0] sz, input logic [31:0] nx,
                              output int done_exp, output int err_exp);
        logic [31:0] d [4];
        logic [31:0] ptr, src, dst;
        bit   more;
        int   code, cnt, stp;
        done_exp = 0;
        err_exp  = 0;
        more     = 1;
        d[0] = dv; d[1] = mm; d[2] = sz; d[3] = nx;
        ptr = {nx[31:2], 2'b00};
        while (more) begin
            if (!single) begin
                for (int k = 0; k < 4; k++) begin
                    exp_q.push_back('{we: 0, addr: ptr + 32'(4 * k), data: 0, tag: "R4"});
                    d[k] = mem[(ptr[13:2] + 12'(k))];
                end
            end
            code = int'(d[2][13:12]);
            cnt  = int'(d[2][10:0]);
            if (code == 1 || (code != 0 && cnt > 'h3FF)) begin
                done_exp++;
                err_exp++;
                more = 0;
            end else begin
                stp = (code == 3) ? 1 : (code == 2) ? 2 : 4;
                for (int e = 0; e < cnt; e++) begin
                    src = to_dev ? d[1] + 32'(e * stp) : d[0];
                    dst = to_dev ? d[0] : d[1] + 32'(e * stp);
                    exp_q.push_back('{we: 0, addr: src, data: 0, tag: "R5"});
                    exp_q.push_back('{we: 1, addr: dst, data: mem[src[13:2]], tag: "R6"});
                end
                if (d[3][0]) done_exp++;
                if (single || !d[3][1]) more = 0;
                else ptr = {d[3][31:2], 2'b00};
            end
        end
    endtask

    task automatic run(input bit single, input bit to_dev,
                       input logic [31:0] dv, input logic [31:0] mm,
                       input logic [31:0] sz, input logic [31:0] nx,
                       input int limit);
        int de, ee, d0, e0, g0, r0;
        expect_run(single, to_dev, dv, mm, sz, nx, de, ee);
        @(negedge clk);
        d0 = n_done; e0 = n_err; g0 = grants; r0 = n_elem_rd;
        cfg_mode     = single ? 2'd2 : 2'd1;
        cfg_to_dev   = to_dev;
        reg_dev_addr = dv; reg_mem_addr = mm; reg_size = sz; reg_next = nx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(state_o == 2'd1, "R2", "state after start", 32'(state_o), 32'd1);
        for (int i = 0; i < limit; i++) begin
            if (state_o == 2'd0) break;
            @(negedge clk);
            #1;
        end
        check(state_o == 2'd0, "R2", "idle at end", 32'(state_o), 32'd0);
        check(exp_q.size() == 0, "R6", "beats outstanding", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        check(n_done - d0 == de, "R9", "done pulses", 32'(n_done - d0), 32'(de));
        check(n_err - e0 == ee, "R8", "error pulses", 32'(n_err - e0), 32'(ee));
        check(n_elem_rd - r0 == grants - g0, "R7", "elements per request",
              32'(n_elem_rd - r0), 32'(grants - g0));
        cfg_mode = 2'd0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'hC0DE0000 | 32'(i);

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(state_o == 2'd0, "R1", "state in reset", 32'(state_o), 32'd0);
        check(!m_req, "R1", "request in reset", 32'(m_req), 32'd0);
        check(!done_o && !err_o, "R1", "pulses in reset", {30'd0, done_o, err_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(state_o == 2'd0 && !m_req, "R1", "idle after reset", 32'(state_o), 32'd0);

        // R3 R5 R6: single, 4-byte, memory to device, interrupt
        run(1, 1, 32'h3F00, 32'h0100, 32'h0000_0003, 32'h1, 200);
        // R5 R9: single, 1-byte width, no interrupt
        run(1, 1, 32'h3F00, 32'h0200, 32'h0000_3002, 32'h0, 200);

        // R4 R12: three-descriptor chain under stalls and sparse requests
        mem[12'h200] = 32'h3F40; mem[12'h201] = 32'h0300; mem[12'h202] = 32'h2002; mem[12'h203] = 32'h0812;
        mem[12'h204] = 32'h3F40; mem[12'h205] = 32'h0340; mem[12'h206] = 32'h2001; mem[12'h207] = 32'h0823;
        mem[12'h208] = 32'h3F40; mem[12'h209] = 32'h0380; mem[12'h20A] = 32'h0002; mem[12'h20B] = 32'h0001;
        ack_stall = 1; dreq_sparse = 1;
        run(0, 0, 32'h0, 32'h0, 32'h0, 32'h0802, 2000);
        ack_stall = 0; dreq_sparse = 0;

        // R8: chain descriptor with width code 1
        mem[12'h210] = 32'h3F40; mem[12'h211] = 32'h0400; mem[12'h212] = 32'h1001; mem[12'h213] = 32'h0001;
        run(0, 1, 32'h0, 32'h0, 32'h0, 32'h0840, 200);
        // R8: narrow count just above limit
        run(1, 1, 32'h3F00, 32'h0100, 32'h0000_3400, 32'h1, 200);
        // R8: 2-byte width at its limit is accepted
        run(1, 1, 32'h3F00, 32'h0000, 32'h0000_23FF, 32'h1, 20000);
        // R8: 4-byte width at the full count is accepted
        run(1, 1, 32'h3F80, 32'h0000, 32'h0000_07FF, 32'h1, 40000);
        // R3: follow bit ignored in single mode
        run(1, 1, 32'h3F00, 32'h0500, 32'h0000_0001, 32'h3, 200);
        // R11: zero count still ends with interrupt
        run(1, 0, 32'h3F00, 32'h0600, 32'h0000_0000, 32'h1, 200);

        // R7 R10: wait holds without requests, then abort
        begin
            int o0;
            dreq_low = 1;
            @(negedge clk);
            o0 = n_ops;
            cfg_mode = 2'd2; cfg_to_dev = 1;
            reg_dev_addr = 32'h3F00; reg_mem_addr = 32'h0140;
            reg_size = 32'h0000_0005; reg_next = 32'h1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (20) @(negedge clk);
            #1;
            check(state_o == 2'd2, "R7", "held in wait", 32'(state_o), 32'd2);
            check(n_ops == o0, "R7", "no beats in wait", 32'(n_ops - o0), 32'd0);
            cfg_mode = 2'd0;
            repeat (2) @(negedge clk);
            #1;
            check(state_o == 2'd0, "R10", "idle after abort", 32'(state_o), 32'd0);
            dreq_low = 0;
            repeat (4) @(negedge clk);
            #1;
            check(n_ops == o0, "R10", "no beats after abort", 32'(n_ops - o0), 32'd0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 32'(state_o), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule